// File: doc/BRIEF.md
# Delta-decoded CSR sparse matrix-vector streamer

This block computes y = A·x for a sparse matrix A held in compressed sparse row form. The matrix arrives on three independent valid/ready streams. The first stream carries row pointers. The second carries column indices, sent as first differences. The third carries the nonzero values. The dense vector x is held in a small local memory that is written through a simple write port before a run starts.

A run starts with a one-cycle `start_i` pulse, which captures the row count m. The block then takes m+1 row pointers. Each pair of adjacent pointers frames one row. The block rebuilds the absolute column index of every nonzero from its difference, multiplies the value by the matching x entry, and adds the product into a 40-bit accumulator. When a row is complete, the accumulated sum is clamped to the output width and offered on the result port. A one-cycle done pulse follows acceptance of the last row.

Top module: `csr_spmv_stream`

## Requirements
- R1: After reset, `y_valid_o`, `done_o`, `ptr_ready_o`, `idx_ready_o` and `val_ready_o` are all 0.
- R2: A run of m rows consumes exactly m+1 row pointers. When the result for row i is offered, exactly p(i+1) index entries and p(i+1) value entries have been consumed, and i+2 pointers have been taken, where p(k) is pointer k.
- R3: The column index of a nonzero is the index of the previous nonzero in the same row plus the received 3-bit unsigned difference. The first difference of each row is the absolute column index.
- R4: Each row result equals the sum over its nonzeros of value·x(column). Values and x are 16-bit two's complement, and each nonzero costs one multiply and one add.
- R5: A row whose two framing pointers are equal yields a result of 0 and consumes no index or value entries.
- R6: The result is the 40-bit sum saturated to 32-bit two's complement: sums above 2^31-1 give 2^31-1, and sums below -2^31 give -2^31.
- R7: Exactly one result is produced per row, in row order. While `y_valid_o` is 1 and `y_ready_i` is 0, the result stays valid and unchanged.
- R8: An index entry and a value entry are taken only together, in the same cycle, and only when both streams are valid. No stream input is taken while a result is being offered.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last row's result is accepted, and at no other time.
- R10: Writes on the x port (`x_we_i`, `x_addr_i`, `x_data_i`) replace x entries for later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; captures `num_rows_i` |
| num_rows_i | input | 4 | Row count m |
| x_we_i | input | 1 | x memory write enable |
| x_addr_i | input | 3 | x memory write address |
| x_data_i | input | 16 | x entry, signed |
| ptr_valid_i | input | 1 | Row pointer valid |
| ptr_ready_o | output | 1 | Row pointer taken |
| ptr_data_i | input | 16 | Row pointer value |
| idx_valid_i | input | 1 | Column difference valid |
| idx_ready_o | output | 1 | Column difference taken |
| idx_delta_i | input | 3 | Column difference, unsigned |
| val_valid_i | input | 1 | Matrix value valid |
| val_ready_o | output | 1 | Matrix value taken |
| val_data_i | input | 16 | Matrix value, signed |
| y_valid_o | output | 1 | Row result valid |
| y_ready_i | input | 1 | Row result accepted |
| y_data_o | output | 32 | Saturated row result, signed |
| done_o | output | 1 | One-cycle pulse after the last result is accepted |

## Verification
The hardest case to reach from the ports is a result held under back-pressure while the stream inputs keep offering data. This matters most when the held row is empty or is the final row, because then the next pointer, or the done pulse, must wait for the accept. The stimulus sweeps generated matrices of every row count from 1 to 8 at several densities. In some sweeps each stream has its own stall pattern, phase-shifted from the others, so that stalls land on empty rows, row ends and the last row. Dedicated matrices drive the sums past both 32-bit limits and reload x between runs.

// File: rtl/csr_spmv_pkg.sv
package csr_spmv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_PTR,
    ST_MAC,
    ST_EMIT
  } csr_state_e;
endpackage

// File: rtl/csr_xmem.sv
module csr_xmem #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int DW    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        wa_i,
  input  logic signed [DW-1:0] wd_i,
  input  logic [AW-1:0]        ra_i,
  output logic signed [DW-1:0] rd_o
);
  logic signed [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[g] <= '0;
      else if (we_i && wa_i == AW'(g))     mem_q[g] <= wd_i;
    end
  end

  assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/csr_col_rebuild.sv
module csr_col_rebuild #(
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_start_i,
  input  logic          step_i,
  input  logic [IW-1:0] delta_i,
  output logic [IW-1:0] col_o
);
  logic [IW-1:0] base_q;
  logic          first_q;

  // first delta of a row is absolute
  assign col_o = first_q ? delta_i : base_q + delta_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      first_q <= 1'b1;
    end else if (row_start_i) begin
      base_q  <= '0;
      first_q <= 1'b1;
    end else if (step_i) begin
      base_q  <= col_o;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/csr_mac.sv
module csr_mac #(
  parameter int VW = 16,
  parameter int AW = 40,
  parameter int YW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 step_i,
  input  logic signed [VW-1:0] a_i,
  input  logic signed [VW-1:0] x_i,
  output logic signed [YW-1:0] y_o
);
  localparam int PW = 2 * VW;
  localparam int HW = AW - YW + 1;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] acc_q;
  logic        [HW-1:0] top_bits;

  assign prod     = a_i * x_i;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= acc_q + prod_ext;
  end

  // clamp when the bits above the output sign disagree
  assign top_bits = acc_q[AW-1:YW-1];

  always_comb begin
    if (top_bits == '0 || top_bits == '1) y_o = acc_q[YW-1:0];
    else if (acc_q[AW-1])                 y_o = {1'b1, {(YW-1){1'b0}}};
    else                                  y_o = {1'b0, {(YW-1){1'b1}}};
  end
endmodule

// File: rtl/csr_spmv_stream.sv
module csr_spmv_stream
  import csr_spmv_pkg::*;
#(
  parameter int ROWS_MAX = 8,
  parameter int COLS     = 8,
  parameter int PTR_W    = 16,
  parameter int VAL_W    = 16,
  parameter int ACC_W    = 40,
  parameter int Y_W      = 32,
  localparam int IDX_W   = $clog2(COLS),
  localparam int ROW_W   = $clog2(ROWS_MAX + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ROW_W-1:0]        num_rows_i,
  input  logic                    x_we_i,
  input  logic [IDX_W-1:0]        x_addr_i,
  input  logic signed [VAL_W-1:0] x_data_i,
  input  logic                    ptr_valid_i,
  output logic                    ptr_ready_o,
  input  logic [PTR_W-1:0]        ptr_data_i,
  input  logic                    idx_valid_i,
  output logic                    idx_ready_o,
  input  logic [IDX_W-1:0]        idx_delta_i,
  input  logic                    val_valid_i,
  output logic                    val_ready_o,
  input  logic signed [VAL_W-1:0] val_data_i,
  output logic                    y_valid_o,
  input  logic                    y_ready_i,
  output logic signed [Y_W-1:0]   y_data_o,
  output logic                    done_o
);
  csr_state_e       state_q;
  logic [ROW_W-1:0] rows_q, row_q;
  logic [PTR_W-1:0] beg_q, left_q;
  logic             done_q;

  logic ptr_fire, pair_fire, out_fire, row_open, last_row;
  logic [IDX_W-1:0] col;
  logic signed [VAL_W-1:0] x_rd;

  assign ptr_ready_o = (state_q == ST_HEAD) || (state_q == ST_PTR);
  assign ptr_fire    = ptr_ready_o && ptr_valid_i;
  assign pair_fire   = (state_q == ST_MAC) && idx_valid_i && val_valid_i;
  assign idx_ready_o = pair_fire;
  assign val_ready_o = pair_fire;
  assign y_valid_o   = (state_q == ST_EMIT);
  assign out_fire    = y_valid_o && y_ready_i;
  assign row_open    = (state_q == ST_PTR) && ptr_fire;
  assign last_row    = (row_q == rows_q - ROW_W'(1));
  assign done_o      = done_q;

  csr_xmem #(.DEPTH(COLS), .AW(IDX_W), .DW(VAL_W)) u_xmem (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (x_we_i),
    .wa_i  (x_addr_i),
    .wd_i  (x_data_i),
    .ra_i  (col),
    .rd_o  (x_rd)
  );

  csr_col_rebuild #(.IW(IDX_W)) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_start_i(row_open),
    .step_i     (pair_fire),
    .delta_i    (idx_delta_i),
    .col_o      (col)
  );

  csr_mac #(.VW(VAL_W), .AW(ACC_W), .YW(Y_W)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(row_open),
    .step_i (pair_fire),
    .a_i    (val_data_i),
    .x_i    (x_rd),
    .y_o    (y_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rows_q  <= '0;
      row_q   <= '0;
      beg_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rows_q  <= num_rows_i;
          row_q   <= '0;
          state_q <= ST_HEAD;
        end
        ST_HEAD: if (ptr_fire) begin
          beg_q <= ptr_data_i;
          if (rows_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PTR;
          end
        end
        ST_PTR: if (ptr_fire) begin
          left_q  <= ptr_data_i - beg_q;
          beg_q   <= ptr_data_i;
          state_q <= (ptr_data_i == beg_q) ? ST_EMIT : ST_MAC;
        end
        ST_MAC: if (pair_fire) begin
          left_q <= left_q - PTR_W'(1);
          if (left_q == PTR_W'(1)) state_q <= ST_EMIT;
        end
        ST_EMIT: if (out_fire) begin
          if (last_row) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            row_q   <= row_q + ROW_W'(1);
            state_q <= ST_PTR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csr_spmv_stream_chk.sv
module csr_spmv_stream_chk #(
  parameter int Y_W = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ptr_ready_o,
  input logic           idx_valid_i,
  input logic           idx_ready_o,
  input logic           val_valid_i,
  input logic           val_ready_o,
  input logic           y_valid_o,
  input logic           y_ready_i,
  input logic [Y_W-1:0] y_data_o,
  input logic           done_o
);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && !y_ready_i) |=> (y_valid_o && $stable(y_data_o)));

  assert_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_valid_i && idx_ready_o) |-> (val_valid_i && val_ready_o));

  assert_quiet_emit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> (!ptr_ready_o && !idx_ready_o && !val_ready_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(ptr_ready_o)) |-> $past(y_valid_o && y_ready_i));
endmodule

bind csr_spmv_stream csr_spmv_stream_chk #(.Y_W(Y_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ptr_ready_o(ptr_ready_o),
  .idx_valid_i(idx_valid_i),
  .idx_ready_o(idx_ready_o),
  .val_valid_i(val_valid_i),
  .val_ready_o(val_ready_o),
  .y_valid_o  (y_valid_o),
  .y_ready_i  (y_ready_i),
  .y_data_o   (y_data_o),
  .done_o     (done_o)
);

// File: tb/csr_spmv_stream_test.sv
`timescale 1ns/1ps
module csr_spmv_stream_test;
  localparam int COLS = 8;
  localparam int RMAX = 8;
  localparam int NMAX = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start_i = 1'b0;
  logic [3:0] num_rows_i = '0;
  logic x_we_i = 1'b0;
  logic [2:0] x_addr_i = '0;
  logic signed [15:0] x_data_i = '0;
  logic ptr_valid_i = 1'b0, ptr_ready_o;
  logic [15:0] ptr_data_i = '0;
  logic idx_valid_i = 1'b0, idx_ready_o;
  logic [2:0] idx_delta_i = '0;
  logic val_valid_i = 1'b0, val_ready_o;
  logic signed [15:0] val_data_i = '0;
  logic y_valid_o, y_ready_i = 1'b0, done_o;
  logic signed [31:0] y_data_o;

  csr_spmv_stream uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .num_rows_i(num_rows_i),
    .x_we_i(x_we_i), .x_addr_i(x_addr_i), .x_data_i(x_data_i),
    .ptr_valid_i(ptr_valid_i), .ptr_ready_o(ptr_ready_o), .ptr_data_i(ptr_data_i),
    .idx_valid_i(idx_valid_i), .idx_ready_o(idx_ready_o), .idx_delta_i(idx_delta_i),
    .val_valid_i(val_valid_i), .val_ready_o(val_ready_o), .val_data_i(val_data_i),
    .y_valid_o(y_valid_o), .y_ready_i(y_ready_i), .y_data_o(y_data_o), .done_o(done_o)
  );

  int total = 0, bad = 0;
  int ptr_q [RMAX+1];
  int dlt_q [NMAX];
  int val_q [NMAX];
  int xv    [COLS];
  longint exp_y [RMAX];
  int m_cur = 0, nnz = 0;
  bit stall = 1'b0;
  int req_cnt = 0, done_cnt = 0;

  int ptr_n = 0, idx_n = 0, val_n = 0;
  int out_n = 0, ack_cnt = 0, cyc = 0;
  bit running = 1'b0, expect_done = 1'b0, held = 1'b0;
  logic signed [31:0] held_y = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit gap(input int k);
    return stall && (((cyc + 5 * k) % (3 + k)) == 0);
  endfunction

  function automatic longint sat32(input longint s);
    if (s > 64'sd2147483647) return 64'sd2147483647;
    if (s < -64'sd2147483648) return -64'sd2147483648;
    return s;
  endfunction

  always @(posedge clk) begin
    if (start_i) begin
      ptr_n <= 0; idx_n <= 0; val_n <= 0;
    end else begin
      if (ptr_valid_i && ptr_ready_o) ptr_n <= ptr_n + 1;
      if (idx_valid_i && idx_ready_o) idx_n <= idx_n + 1;
      if (val_valid_i && val_ready_o) val_n <= val_n + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    start_i = 1'b0;
    if (rst_n && !running && req_cnt != ack_cnt) begin
      ack_cnt = req_cnt;
      running = 1'b1;
      num_rows_i = 4'(m_cur);
      start_i = 1'b1;
      out_n = 0;
    end
    ptr_valid_i = running && !start_i && (ptr_n <= m_cur) && !gap(0);
    ptr_data_i  = 16'(ptr_q[ptr_n <= m_cur ? ptr_n : m_cur]);
    idx_valid_i = running && (idx_n < nnz) && !gap(1);
    idx_delta_i = 3'(dlt_q[idx_n < nnz ? idx_n : 0]);
    val_valid_i = running && (val_n < nnz) && !gap(2);
    val_data_i  = 16'(val_q[val_n < nnz ? val_n : 0]);
    y_ready_i   = !gap(3);

    if (held) begin
      chk(y_valid_o && y_data_o == held_y, "R7 hold", longint'(y_data_o), longint'(held_y));
    end
    held = 1'b0;

    if (expect_done) begin
      chk(done_o === 1'b1, "R9 done timing", longint'(done_o), 1);
      chk(ptr_n == m_cur + 1, "R2 pointer count", ptr_n, m_cur + 1);
      chk(idx_n == nnz && val_n == nnz, "R8 pair count", idx_n, nnz);
      expect_done = 1'b0;
      running = 1'b0;
      done_cnt++;
    end else if (done_o) begin
      chk(1'b0, "R9 stray done", 1, 0);
    end

    if (y_valid_o) begin
      if (!y_ready_i) begin
        held = 1'b1;
        held_y = y_data_o;
      end else if (out_n >= m_cur) begin
        chk(1'b0, "R7 extra result", out_n, m_cur);
      end else begin
        chk(longint'(y_data_o) == exp_y[out_n], "R4 R6 row value",
            longint'(y_data_o), exp_y[out_n]);
        chk(idx_n == ptr_q[out_n+1] && val_n == ptr_q[out_n+1] && ptr_n == out_n + 2,
            "R2 R5 consumed at row end", idx_n, ptr_q[out_n+1]);
        out_n = out_n + 1;
        if (out_n == m_cur) expect_done = 1'b1;
      end
    end
  end

  task automatic load_x;
    for (int c = 0; c < COLS; c++) begin
      @(negedge clk);
      x_we_i = 1'b1; x_addr_i = 3'(c); x_data_i = 16'(xv[c]);
    end
    @(negedge clk);
    x_we_i = 1'b0;
  endtask

  task automatic run_case(input string name);
    int waited = 0;
    load_x();
    req_cnt++;
    while (done_cnt != req_cnt && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (done_cnt != req_cnt) begin
      chk(1'b0, {"R7 watchdog ", name}, waited, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // dens 0 = no nonzeros, otherwise keep 1 in dens columns
  task automatic build(input int unsigned seed, input int m, input int dens);
    int unsigned s = seed * 7919 + 13;
    longint acc;
    int pc;
    nnz = 0;
    m_cur = m;
    for (int c = 0; c < COLS; c++) begin
      s = s * 1103515245 + 12345;
      xv[c] = int'($signed(16'(s >> 9)));
    end
    for (int r = 0; r < m; r++) begin
      ptr_q[r] = nnz;
      acc = 0;
      pc = 0;
      for (int c = 0; c < COLS; c++) begin
        s = s * 1103515245 + 12345;
        if (dens != 0 && ((s >> 16) % dens) == 0) begin
          val_q[nnz] = int'($signed(16'(s >> 5)));
          dlt_q[nnz] = (nnz == ptr_q[r]) ? c : c - pc; // R3: first is absolute
          pc = c;
          acc += longint'(val_q[nnz]) * longint'(xv[c]);
          nnz++;
        end
      end
      exp_y[r] = sat32(acc);
    end
    ptr_q[m] = nnz;
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!y_valid_o && !done_o, "R1 reset outputs", longint'({y_valid_o, done_o}), 0);
    chk(!ptr_ready_o && !idx_ready_o && !val_ready_o, "R1 reset readies",
        longint'({ptr_ready_o, idx_ready_o, val_ready_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 all-empty rows
    build(1, 3, 0);
    run_case("empty");
    // R4 dense rows, R3 column reset per row
    build(2, 4, 1);
    run_case("dense");

    // sweep over sizes, densities, stall patterns (R2 R3 R4 R7 R10)
    for (int sd = 3; sd < 35; sd++) begin
      stall = sd[0];
      build(sd, 1 + (sd % 8), 1 + (sd % 4));
      run_case("sweep");
    end

    // R6 saturation both directions, R10 new x contents
    stall = 1'b1;
    m_cur = 3;
    for (int c = 0; c < COLS; c++) xv[c] = 32767;
    nnz = 0;
    ptr_q[0] = 0;
    for (int k = 0; k < 4; k++) begin val_q[nnz] = 32767;  dlt_q[nnz] = (k == 0) ? 0 : 1; nnz++; end
    ptr_q[1] = nnz;
    for (int k = 0; k < 5; k++) begin val_q[nnz] = -32768; dlt_q[nnz] = (k == 0) ? 2 : 1; nnz++; end
    ptr_q[2] = nnz;
    val_q[nnz] = 3; dlt_q[nnz] = 7; nnz++;
    ptr_q[3] = nnz;
    exp_y[0] = 64'sd2147483647;
    exp_y[1] = -64'sd2147483648;
    exp_y[2] = 64'sd98301;
    run_case("saturate");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL R9 global watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule